// File: doc/BRIEF.md
# Register-Mapped Multiply/Divide Coprocessor

This block gives a host on an 8-bit register bus a 16x16 multiplier and a 32/16 divider. The host loads operands one byte at a time through a 4-bit register select. Writing the upper byte of the multiplier starts a product, and writing the upper byte of the divisor starts a quotient. Both run on a sequential datapath: shift-add for the product and restoring subtraction for the quotient.

A mode register chooses unsigned or two's-complement arithmetic. Any write to it zeroes every operand and result register and abandons a running operation. Software polls a status byte to see that an operation has finished; that byte reads 0x80 once and then reads 0x00 until the next completion.

Top module: `arith_coproc`

## Requirements
- R1: Select values 0x0..0x3 hold the 32-bit dividend, least significant byte at 0x0. The multiplicand is dividend bits 15:0. Select 0x4/0x5 hold the multiplier (low/high) and 0x6/0x7 hold the divisor (low/high). All of them read back what was written.
- R2: A write to select 0x5 starts a multiply. On completion, selects 0x8..0xB (least significant first) return the 32-bit product.
- R3: A write to select 0x7 starts a divide. On completion, selects 0x8..0xB return the 32-bit quotient and selects 0xC/0xD return the 16-bit remainder.
- R4: Mode bit 0 set selects signed arithmetic, and bit 0 clear selects unsigned. In signed mode the quotient truncates toward zero, the remainder carries the sign of the dividend, and results wrap to their register width (so -2^31 / -1 gives 0x80000000 with remainder 0).
- R5: A divisor of zero gives a quotient of 0xFFFFFFFF and a remainder equal to dividend bits 15:0, in either mode. It still sets the finished flag.
- R6: A write to select 0xE stores the byte as the mode and zeroes selects 0x0..0xD. It also stops any running operation without setting the finished flag.
- R7: Select 0xF reads 0x80 after a completion. That read clears the flag, so later reads give 0x00. A completion in the same cycle as a status read leaves the flag set.
- R8: `busy` rises at the trigger edge and stays high for 17 cycles for a multiply and 33 cycles for a divide. It falls in the same cycle the flag and results become visible.
- R9: A trigger write during a running operation restarts it from the current operand values. A trigger of the other operation abandons the running one.
- R10: After reset every select reads 0x00. Writes to selects 0x8..0xD and 0xF have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| rd_en | input | 1 | Register read strobe, one cycle |
| reg_sel | input | 4 | Register select (offset within the block) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational from selected register) |
| busy | output | 1 | Operation in progress |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle, because a single bus carries one access at a time. They also assume each strobe marks one access per cycle, so a status read consumes the flag exactly once. The bench drives exactly one of the strobes for one cycle per access, changing inputs on the falling edge. Retriggering and mode writes are issued mid-operation at chosen cycle counts, so the restart and abort paths are reached inside these limits.

// File: rtl/arith_pkg.sv
package arith_pkg;
    localparam int OPW = 16;
    localparam int RESW = 2 * OPW;

    typedef enum logic [3:0] {
        SEL_DVD0 = 4'h0, SEL_DVD1 = 4'h1, SEL_DVD2 = 4'h2, SEL_DVD3 = 4'h3,
        SEL_MLR0 = 4'h4, SEL_MLR1 = 4'h5, SEL_DVS0 = 4'h6, SEL_DVS1 = 4'h7,
        SEL_RES0 = 4'h8, SEL_RES1 = 4'h9, SEL_RES2 = 4'hA, SEL_RES3 = 4'hB,
        SEL_REM0 = 4'hC, SEL_REM1 = 4'hD, SEL_MODE = 4'hE, SEL_STAT = 4'hF
    } reg_sel_e;

    localparam logic [7:0] STAT_DONE = 8'h80;
endpackage

// File: rtl/arith_mul_seq.sv
module arith_mul_seq #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           cancel,
    input  logic           signed_mode,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    localparam int PW = 2 * W;
    localparam int CW = $clog2(W);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          neg;
        logic [CW-1:0] cnt;
        logic [PW-1:0] acc;
        logic [PW-1:0] sh_mcand;
        logic [W-1:0]  sh_mplier;
        logic [PW-1:0] result;
    } mul_st_t;

    mul_st_t st_d, st_q;

    function automatic logic [W-1:0] magnitude(input logic [W-1:0] x, input logic s);
        return (s && x[W-1]) ? (~x + W'(1)) : x;
    endfunction

    always_comb begin
        logic [PW-1:0] acc_n;
        st_d      = st_q;
        st_d.done = 1'b0;
        acc_n     = st_q.acc + (st_q.sh_mplier[0] ? st_q.sh_mcand : '0);
        if (start) begin
            st_d.busy      = 1'b1;
            st_d.cnt       = '0;
            st_d.acc       = '0;
            st_d.neg       = signed_mode & (mcand[W-1] ^ mplier[W-1]);
            st_d.sh_mcand  = {{W{1'b0}}, magnitude(mcand, signed_mode)};
            st_d.sh_mplier = magnitude(mplier, signed_mode);
        end else if (cancel) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            st_d.acc       = acc_n;
            st_d.sh_mcand  = {st_q.sh_mcand[PW-2:0], 1'b0};
            st_d.sh_mplier = {1'b0, st_q.sh_mplier[W-1:1]};
            st_d.cnt       = st_q.cnt + CW'(1);
            if (st_q.cnt == CW'(W - 1)) begin
                st_d.busy   = 1'b0;
                st_d.done   = 1'b1;
                st_d.result = st_q.neg ? (~acc_n + PW'(1)) : acc_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign product = st_q.result;
endmodule

// File: rtl/arith_div_seq.sv
module arith_div_seq #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           cancel,
    input  logic           signed_mode,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] quotient,
    output logic [W-1:0]   remainder
);
    localparam int DW = 2 * W;
    localparam int CW = $clog2(DW);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          qneg;
        logic          rneg;
        logic          dz;
        logic [W-1:0]  raw_lo;
        logic [CW-1:0] cnt;
        logic [DW-1:0] quo;
        logic [W-1:0]  rem;
        logic [W-1:0]  dvs;
        logic [DW-1:0] quo_res;
        logic [W-1:0]  rem_res;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        logic [W:0]    trial;
        logic [W:0]    diff;
        logic          fits;
        logic [W-1:0]  rem_n;
        logic [DW-1:0] quo_n;
        st_d      = st_q;
        st_d.done = 1'b0;
        trial     = {st_q.rem, st_q.quo[DW-1]};
        diff      = trial - {1'b0, st_q.dvs};
        fits      = trial >= {1'b0, st_q.dvs};
        rem_n     = fits ? diff[W-1:0] : trial[W-1:0];
        quo_n     = {st_q.quo[DW-2:0], fits};
        if (start) begin
            st_d.busy   = 1'b1;
            st_d.cnt    = '0;
            st_d.rem    = '0;
            st_d.dz     = (divisor == '0);
            st_d.raw_lo = dividend[W-1:0];
            st_d.rneg   = signed_mode & dividend[DW-1];
            st_d.qneg   = signed_mode & (dividend[DW-1] ^ divisor[W-1]);
            st_d.quo    = (signed_mode && dividend[DW-1]) ? (~dividend + DW'(1)) : dividend;
            st_d.dvs    = (signed_mode && divisor[W-1]) ? (~divisor + W'(1)) : divisor;
        end else if (cancel) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            st_d.rem = rem_n;
            st_d.quo = quo_n;
            st_d.cnt = st_q.cnt + CW'(1);
            if (st_q.cnt == CW'(DW - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                if (st_q.dz) begin
                    st_d.quo_res = '1;
                    st_d.rem_res = st_q.raw_lo;
                end else begin
                    st_d.quo_res = st_q.qneg ? (~quo_n + DW'(1)) : quo_n;
                    st_d.rem_res = st_q.rneg ? (~rem_n + W'(1)) : rem_n;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign quotient  = st_q.quo_res;
    assign remainder = st_q.rem_res;
endmodule

// File: rtl/arith_coproc.sv
module arith_coproc
    import arith_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [3:0] reg_sel,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       busy
);
    typedef struct packed {
        logic [RESW-1:0] dvd;
        logic [OPW-1:0]  mlr;
        logic [OPW-1:0]  dvs;
        logic [RESW-1:0] res;
        logic [OPW-1:0]  rem;
        logic [7:0]      mode;
        logic            flag;
    } rf_t;

    rf_t rf_d, rf_q;

    logic            mul_start, div_start, mode_wr;
    logic            mul_busy, mul_done, div_busy, div_done;
    logic [RESW-1:0] mul_prod, div_quo;
    logic [OPW-1:0]  div_rem;

    // Views for the bound checker
    logic            stat_flag, any_done;
    logic [RESW-1:0] res_view;
    logic [OPW-1:0]  rem_view;

    assign mul_start = wr_en && (reg_sel == SEL_MLR1);
    assign div_start = wr_en && (reg_sel == SEL_DVS1);
    assign mode_wr   = wr_en && (reg_sel == SEL_MODE);

    always_comb begin
        rf_d = rf_q;
        if (mul_done) rf_d.res = mul_prod;
        if (div_done) begin
            rf_d.res = div_quo;
            rf_d.rem = div_rem;
        end
        if (rd_en && reg_sel == SEL_STAT) rf_d.flag = 1'b0;
        if (mul_done || div_done)         rf_d.flag = 1'b1;
        if (wr_en) begin
            case (reg_sel)
                SEL_DVD0: rf_d.dvd[7:0]   = wdata;
                SEL_DVD1: rf_d.dvd[15:8]  = wdata;
                SEL_DVD2: rf_d.dvd[23:16] = wdata;
                SEL_DVD3: rf_d.dvd[31:24] = wdata;
                SEL_MLR0: rf_d.mlr[7:0]   = wdata;
                SEL_MLR1: rf_d.mlr[15:8]  = wdata;
                SEL_DVS0: rf_d.dvs[7:0]   = wdata;
                SEL_DVS1: rf_d.dvs[15:8]  = wdata;
                SEL_MODE: begin
                    rf_d.dvd  = '0;
                    rf_d.mlr  = '0;
                    rf_d.dvs  = '0;
                    rf_d.res  = '0;
                    rf_d.rem  = '0;
                    rf_d.mode = wdata;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    arith_mul_seq #(.W(OPW)) u_mul (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (mul_start),
        .cancel      (div_start | mode_wr),
        .signed_mode (rf_q.mode[0]),
        .mcand       (rf_d.dvd[OPW-1:0]),
        .mplier      (rf_d.mlr),
        .busy        (mul_busy),
        .done        (mul_done),
        .product     (mul_prod)
    );

    arith_div_seq #(.W(OPW)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (div_start),
        .cancel      (mul_start | mode_wr),
        .signed_mode (rf_q.mode[0]),
        .dividend    (rf_d.dvd),
        .divisor     (rf_d.dvs),
        .busy        (div_busy),
        .done        (div_done),
        .quotient    (div_quo),
        .remainder   (div_rem)
    );

    always_comb begin
        case (reg_sel)
            SEL_DVD0: rdata = rf_q.dvd[7:0];
            SEL_DVD1: rdata = rf_q.dvd[15:8];
            SEL_DVD2: rdata = rf_q.dvd[23:16];
            SEL_DVD3: rdata = rf_q.dvd[31:24];
            SEL_MLR0: rdata = rf_q.mlr[7:0];
            SEL_MLR1: rdata = rf_q.mlr[15:8];
            SEL_DVS0: rdata = rf_q.dvs[7:0];
            SEL_DVS1: rdata = rf_q.dvs[15:8];
            SEL_RES0: rdata = rf_q.res[7:0];
            SEL_RES1: rdata = rf_q.res[15:8];
            SEL_RES2: rdata = rf_q.res[23:16];
            SEL_RES3: rdata = rf_q.res[31:24];
            SEL_REM0: rdata = rf_q.rem[7:0];
            SEL_REM1: rdata = rf_q.rem[15:8];
            SEL_MODE: rdata = rf_q.mode;
            default:  rdata = rf_q.flag ? STAT_DONE : 8'h00;
        endcase
    end

    assign busy      = mul_busy | div_busy | mul_done | div_done;
    assign stat_flag = rf_q.flag;
    assign any_done  = mul_done | div_done;
    assign res_view  = rf_q.res;
    assign rem_view  = rf_q.rem;
endmodule

// File: rtl/arith_coproc_chk.sv
module arith_coproc_chk #(
    parameter int MUL_STEPS = 16,
    parameter int DIV_STEPS = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [3:0]  reg_sel,
    input logic        stat_flag,
    input logic        any_done,
    input logic        mul_busy,
    input logic        div_busy,
    input logic [31:0] res_view,
    input logic [15:0] rem_view
);
    localparam int RCW = $clog2(DIV_STEPS + 2) + 1;

    logic [RCW-1:0] mul_run, div_run;
    logic           mul_trig, div_trig, mode_trig;

    assign mul_trig  = wr_en && reg_sel == 4'h5;
    assign div_trig  = wr_en && reg_sel == 4'h7;
    assign mode_trig = wr_en && reg_sel == 4'hE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mul_run <= '0;
            div_run <= '0;
        end else begin
            mul_run <= mul_trig ? '0 : (mul_busy ? mul_run + RCW'(1) : '0);
            div_run <= div_trig ? '0 : (div_busy ? div_run + RCW'(1) : '0);
        end
    end

    AST_MUL_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        mul_trig |=> mul_busy && !div_busy); // R2
    AST_DIV_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        div_trig |=> div_busy && !mul_busy); // R3
    AST_MODE_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        mode_trig |=> res_view == '0 && rem_view == '0 && !mul_busy && !div_busy); // R6
    AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel == 4'hF && !any_done) |=> !stat_flag); // R7
    AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        any_done |=> stat_flag); // R7
    AST_MUL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(mul_run) <= MUL_STEPS); // R8
    AST_DIV_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(div_run) <= DIV_STEPS); // R8
    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mul_busy && div_busy)); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_done && !mode_trig) |=> $stable(res_view) && $stable(rem_view)); // R10
endmodule

bind arith_coproc arith_coproc_chk #(.MUL_STEPS(16), .DIV_STEPS(32)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .reg_sel   (reg_sel),
    .stat_flag (stat_flag),
    .any_done  (any_done),
    .mul_busy  (mul_busy),
    .div_busy  (div_busy),
    .res_view  (res_view),
    .rem_view  (rem_view)
);

// File: tb/test_arith_coproc.sv
module test_arith_coproc;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] reg_sel = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       busy;

    int n_tests = 0;
    int n_fail  = 0;

    arith_coproc i_arith_coproc (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
        .reg_sel (reg_sel), .wdata (wdata), .rdata (rdata), .busy (busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        wr_en = 1'b1; reg_sel = s; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [7:0] d);
        rd_en = 1'b1; reg_sel = s;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_result(output logic [31:0] r, output logic [15:0] m);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin rd(4'h8 + 4'(i), b); r[8*i +: 8] = b; end
        rd(4'hC, b); m[7:0] = b;
        rd(4'hD, b); m[15:8] = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 100) begin n++; @(negedge clk); end
    endtask

    task automatic load_mul(input logic [15:0] a, input logic [15:0] b);
        wr(4'h0, a[7:0]); wr(4'h1, a[15:8]);
        wr(4'h4, b[7:0]);
    endtask

    task automatic load_div(input logic [31:0] a, input logic [15:0] b);
        for (int i = 0; i < 4; i++) wr(4'(i), a[8*i +: 8]);
        wr(4'h6, b[7:0]);
    endtask

    task automatic do_mul(input string req, input logic [15:0] a, input logic [15:0] b,
                          input logic [31:0] exp);
        logic [31:0] r; logic [15:0] m; int n; logic [7:0] st;
        load_mul(a, b);
        wr(4'h5, b[15:8]);
        count_busy(n);
        chk("R8 multiply busy length", n, 17);
        rd(4'hF, st);
        chk("R7 status after multiply", {24'h0, st}, 32'h80);
        rd_result(r, m);
        chk(req, r, exp);
    endtask

    task automatic do_div(input string req, input logic [31:0] a, input logic [15:0] b,
                          input logic [31:0] expq, input logic [15:0] expr);
        logic [31:0] r; logic [15:0] m; int n; logic [7:0] st;
        load_div(a, b);
        wr(4'h7, b[15:8]);
        count_busy(n);
        chk("R8 divide busy length", n, 33);
        rd(4'hF, st);
        chk("R5/R7 status after divide", {24'h0, st}, 32'h80);
        rd_result(r, m);
        chk({req, " quotient"}, r, expq);
        chk({req, " remainder"}, {16'h0, m}, {16'h0, expr});
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int s = 0; s < 16; s++) begin
            rd(4'(s), v);
            chk("R10 reset value", {24'h0, v}, 32'h0);
        end
        chk("R10 reset busy", {31'h0, busy}, 32'h0);
    endtask

    task automatic t_readback;
        logic [7:0] v;
        for (int s = 0; s < 4; s++) wr(4'(s), 8'h11 * 8'(s + 1));
        wr(4'h4, 8'hA5); wr(4'h6, 8'h5A);
        for (int s = 0; s < 4; s++) begin
            rd(4'(s), v);
            chk("R1 dividend byte readback", {24'h0, v}, {24'h0, 8'h11 * 8'(s + 1)});
        end
        rd(4'h4, v); chk("R1 multiplier low readback", {24'h0, v}, 32'hA5);
        rd(4'h6, v); chk("R1 divisor low readback", {24'h0, v}, 32'h5A);
    endtask

    task automatic t_mul_unsigned;
        wr(4'hE, 8'h00);
        do_mul("R2 unsigned product ffff*ffff", 16'hFFFF, 16'hFFFF, 32'hFFFE0001);
        do_mul("R2 unsigned product 1234*0100", 16'h1234, 16'h0100, 32'h00123400);
    endtask

    task automatic t_mul_signed;
        wr(4'hE, 8'h01);
        do_mul("R4 signed product -3*7", 16'hFFFD, 16'h0007, 32'hFFFFFFEB);
        do_mul("R4 signed product min*min", 16'h8000, 16'h8000, 32'h40000000);
        do_mul("R4 signed product 100*-2", 16'd100, 16'hFFFE, 32'hFFFFFF38);
    endtask

    task automatic t_div_unsigned;
        logic [31:0] a; logic [31:0] q; logic [31:0] r;
        wr(4'hE, 8'h00);
        a = 32'h12345678;
        q = a / 32'h1234; r = a % 32'h1234;
        do_div("R3 unsigned divide", a, 16'h1234, q, r[15:0]);
        do_div("R3 unsigned divide by ffff", 32'hFFFFFFFF, 16'hFFFF, 32'h00010001, 16'h0000);
    endtask

    task automatic t_div_signed;
        wr(4'hE, 8'h01);
        do_div("R4 signed -100/7", 32'hFFFFFF9C, 16'd7, 32'hFFFFFFF2, 16'hFFFE);
        do_div("R4 signed 100/-7", 32'd100, 16'hFFF9, 32'hFFFFFFF2, 16'h0002);
        do_div("R4 signed -2^31/-1", 32'h80000000, 16'hFFFF, 32'h80000000, 16'h0000);
    endtask

    task automatic t_div_zero;
        wr(4'hE, 8'h00);
        do_div("R5 unsigned divide by zero", 32'hABCD1234, 16'h0000, 32'hFFFFFFFF, 16'h1234);
        wr(4'hE, 8'h01);
        do_div("R5 signed divide by zero", 32'h8000FFF0, 16'h0000, 32'hFFFFFFFF, 16'hFFF0);
    endtask

    task automatic t_status;
        logic [7:0] st;
        wr(4'hE, 8'h00);
        load_mul(16'd3, 16'd5);
        wr(4'h5, 8'h00);
        idle(20);
        rd(4'hF, st); chk("R7 first status read", {24'h0, st}, 32'h80);
        rd(4'hF, st); chk("R7 second status read", {24'h0, st}, 32'h00);
        wr(4'hF, 8'h80);
        rd(4'hF, st); chk("R10 status write ignored", {24'h0, st}, 32'h00);
    endtask

    task automatic t_mode_wipe;
        logic [31:0] r; logic [15:0] m; logic [7:0] v;
        wr(4'hE, 8'h00);
        do_div("R3 divide before wipe", 32'd1000, 16'd7, 32'd142, 16'd6);
        wr(4'hE, 8'h3B);
        rd_result(r, m);
        chk("R6 result wiped", r, 32'h0);
        chk("R6 remainder wiped", {16'h0, m}, 32'h0);
        for (int s = 0; s < 8; s++) begin
            rd(4'(s), v);
            chk("R6 operand wiped", {24'h0, v}, 32'h0);
        end
        rd(4'hE, v); chk("R6 mode stored", {24'h0, v}, 32'h3B);
        // Abort mid-operation
        load_mul(16'd9, 16'd9);
        wr(4'h5, 8'h00);
        idle(3);
        wr(4'hE, 8'h00);
        chk("R6 abort drops busy", {31'h0, busy}, 32'h0);
        idle(25);
        rd(4'hF, v); chk("R6 abort sets no flag", {24'h0, v}, 32'h0);
        rd(4'h8, v); chk("R6 abort leaves result zero", {24'h0, v}, 32'h0);
    endtask

    task automatic t_retrigger;
        logic [31:0] r; logic [15:0] m; int n; logic [7:0] st;
        wr(4'hE, 8'h00);
        load_mul(16'd1000, 16'd2);
        wr(4'h5, 8'h00);
        idle(4);
        wr(4'h4, 8'd3);
        wr(4'h5, 8'h00);
        count_busy(n);
        chk("R9 restart busy length", n, 17);
        rd_result(r, m);
        chk("R9 restart uses new operands", r, 32'd3000);
        rd(4'hF, st);
        // Divide then multiply trigger cancels divide
        load_div(32'd500, 16'd5);
        wr(4'h7, 8'h00);
        idle(5);
        wr(4'h4, 8'd7);
        wr(4'h5, 8'h00);
        count_busy(n);
        chk("R9 cross trigger busy length", n, 17);
        rd_result(r, m);
        chk("R9 cross trigger product", r, 32'd3500);
        chk("R9 cross trigger remainder untouched", {16'h0, m}, 32'h0);
        idle(40);
        rd_result(r, m);
        chk("R9 cancelled divide never lands", r, 32'd3500);
    endtask

    task automatic t_ro_writes;
        logic [31:0] r; logic [15:0] m;
        wr(4'hE, 8'h00);
        do_div("R3 divide before ro writes", 32'd77, 16'd10, 32'd7, 16'd7);
        for (int s = 8; s < 14; s++) wr(4'(s), 8'hEE);
        rd_result(r, m);
        chk("R10 result write ignored", r, 32'd7);
        chk("R10 remainder write ignored", {16'h0, m}, 32'd7);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_readback();
        t_mul_unsigned();
        t_mul_signed();
        t_div_unsigned();
        t_div_signed();
        t_div_zero();
        t_status();
        t_mode_wipe();
        t_retrigger();
        t_ro_writes();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule